// File: doc/BRIEF.md
# Byte-Serialized 24-bit RGB Panel Driver

This block drives a 24-bit parallel RGB TFT panel through an 8-bit data bus. For every pixel it puts the blue, green and red bytes on the bus one after another. Two external 8-bit edge-triggered registers share one latch strobe and are wired as a chain. On each strobe the first register loads the bus and the second loads the first register's old value. After two strobes the second register holds blue and the first holds green. The red byte goes straight from the bus to the panel. A dot-clock rising edge then samples all 24 bits.

The block also produces horizontal sync, vertical sync, data-enable and the dot clock. The defaults suit a 480x272 panel at about 60 Hz. The dot clock runs at one sixth of the system clock, so each pixel has a fixed six-cycle slot. A picture with fewer lines than the panel can be centred vertically by splitting the spare lines equally between top and bottom blanking. Pixels come from a ready/valid source that offers one 24-bit word per active dot.

Top module: `lcd_byte_serial_drv`

## Requirements
- R1: While reset is held and on the cycle after it: the bus is zero; the latch, dot clock, data-enable and pix_ready are low; both sync outputs are high; underflow is low.
- R2: For each active pixel the bus carries blue, then green, then red. A latch pulse follows the blue byte and another follows the green byte, so an external two-register chain shows {red=bus, green=first register, blue=second register} at the dot-clock rising edge.
- R3: The bus holds its value for at least one system clock before every rising edge of the latch or the dot clock, and holds it through that edge cycle.
- R4: The dot clock rises exactly once every 6 system clocks, in active and in blanking periods.
- R5: Data-enable, sampled at the dot-clock edge, is high only for dot columns H_BLANK to H_BLANK+H_ACT-1 of displayed lines. The columns of each line are counted from 0, with sync at the start.
- R6: During blanking the bus is zero and no latch pulse is issued. During each active dot exactly two latch pulses are issued.
- R7: hsync_n is low for dot columns 0 to H_SYNC-1 of every line. vsync_n is low for lines 0 to V_SYNC-1 of every frame.
- R8: Displayed lines start at line V_BLANK+(V_ACT-V_SHOWN)/2 and continue for V_SHOWN lines. Lines 0 to V_BLANK-1 are blanking, and the full frame is always V_BLANK+V_ACT lines.
- R9: pix_ready is asserted once for each active dot, and the word is taken when pix_valid is also high. pix_data bits [7:0] are blue, [15:8] green and [23:16] red, and pixels are shown in the order accepted.
- R10: If pix_valid is low when pix_ready is high, that dot is shown black and underflow goes high. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | Source has a pixel word |
| pix_ready | output | 1 | Block takes a pixel this cycle |
| pix_data | input | 24 | Pixel word: red [23:16], green [15:8], blue [7:0] |
| lcd_data | output | 8 | Shared byte bus to register chain and panel |
| lcd_latch | output | 1 | Shared strobe of the external register chain |
| lcd_dclk | output | 1 | Panel dot clock, samples on rising edge |
| lcd_de | output | 1 | Panel data-enable |
| lcd_hsync_n | output | 1 | Horizontal sync, active low |
| lcd_vsync_n | output | 1 | Vertical sync, active low |
| underflow | output | 1 | Sticky missing-pixel flag |

## Verification
The bench models the external register chain as edge-triggered registers and rebuilds every pixel at the dot edge. A swapped byte order or a missing or extra strobe therefore shows up as wrong colours. It checks every dot against computed line and column positions across frames where the vertical picture is centred. An off-by-one window, an uncentred picture or sync on the wrong dots shows up as a data-enable or sync mismatch on a particular dot. Random gaps in pix_valid check that a starved dot comes out black and that underflow latches and is cleared only by reset. Random colours include all-ones and all-zero words. Every latch and dot-clock edge is checked for bus setup, so a bus that changes on the strobe edge is reported.

// File: rtl/lcd_drv_pkg.sv
// Shared types for the byte-serialized panel driver.
// Assumes a fixed six-cycle pixel slot; phase encodings below are used by
// both the timing generator and the slot sequencer.
package lcd_drv_pkg;
    localparam int SLOT_CYCLES = 6;
    localparam logic [2:0] PH_LAST  = 3'd5;
    localparam logic [2:0] PH_RESET = 3'd2;

    // Flags describing one dot position on the panel raster.
    typedef struct packed {
        logic act;   // dot lies in the displayed window
        logic hs;    // dot lies in horizontal sync
        logic vs;    // dot lies in vertical sync
    } dot_flags_t;
endpackage

// File: rtl/lcd_dot_timing.sv
// Raster timing generator.
// Keeps the six-cycle slot phase and the column/line counters of the dot
// currently being sent, and presents the flags of the following dot so the
// sequencer can load them at the slot boundary. Assumes H_SYNC>0, V_SYNC>0,
// H_BLANK>H_SYNC and V_SHOWN<=V_ACT.
module lcd_dot_timing
    import lcd_drv_pkg::*;
#(
    parameter int H_ACT   = 480,
    parameter int H_SYNC  = 2,
    parameter int H_BLANK = 45,
    parameter int V_ACT   = 272,
    parameter int V_SYNC  = 10,
    parameter int V_BLANK = 16,
    parameter int V_SHOWN = 272
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] phase,
    output logic       slot_end,
    output dot_flags_t nxt_flags
);
    localparam int H_TOTAL = H_ACT + H_BLANK;
    localparam int V_TOTAL = V_ACT + V_BLANK;
    localparam int V_TOP   = V_BLANK + (V_ACT - V_SHOWN) / 2;
    localparam int HW      = $clog2(H_TOTAL);
    localparam int VW      = $clog2(V_TOTAL);

    logic [HW-1:0] hcnt, hnxt;
    logic [VW-1:0] vcnt, vnxt;

    assign slot_end = (phase == PH_LAST);

    // Advance the slot phase, wrapping after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase <= PH_RESET;
        else if (slot_end)  phase <= '0;
        else                phase <= phase + 3'd1;
    end

    // Position of the dot that follows the current one.
    always_comb begin
        hnxt = hcnt + HW'(1);
        vnxt = vcnt;
        if (hcnt == HW'(H_TOTAL - 1)) begin
            hnxt = '0;
            vnxt = (vcnt == VW'(V_TOTAL - 1)) ? '0 : vcnt + VW'(1);
        end
    end

    // Raster flags of the following dot.
    always_comb begin
        nxt_flags.act = (hnxt >= HW'(H_BLANK)) && (vnxt >= VW'(V_TOP))
                        && (vnxt < VW'(V_TOP + V_SHOWN));
        nxt_flags.hs  = (hnxt < HW'(H_SYNC));
        nxt_flags.vs  = (vnxt < VW'(V_SYNC));
    end

    // Step the raster counters once per slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (slot_end) begin
            hcnt <= hnxt;
            vcnt <= vnxt;
        end
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= PH_LAST);                                              // R4
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt < HW'(H_TOTAL)) && (vcnt < VW'(V_TOTAL)));                // R8
endmodule

// File: rtl/lcd_slot_seq.sv
// Per-pixel slot sequencer.
// Loads one dot's flags and pixel at each slot boundary, then plays the
// byte/strobe/dot-clock pattern for that slot through registered outputs.
// Output pattern by phase (one register later at the pins):
//   0-1 blue, strobe at 1; 2-3 green, strobe at 3; 4-5 red; dot clock high 5,0,1.
// Assumes an external chain of edge-triggered registers on the strobe.
module lcd_slot_seq
    import lcd_drv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  phase,
    input  logic        slot_end,
    input  dot_flags_t  nxt_flags,
    input  logic        pix_valid,
    input  logic [23:0] pix_data,
    output logic        pix_ready,
    output logic [7:0]  bus_o,
    output logic        latch_o,
    output logic        dclk_o,
    output logic        de_o,
    output logic        hsync_n_o,
    output logic        vsync_n_o,
    output logic        underflow_o
);
    dot_flags_t  cur;
    logic [23:0] pix_q;
    logic [7:0]  byte_sel, bus_d;
    logic        latch_d, dclk_d;

    assign pix_ready = slot_end && nxt_flags.act;

    // Load the next dot's flags and pixel (black when the source is empty).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur   <= '{act: 1'b0, hs: 1'b1, vs: 1'b1};
            pix_q <= '0;
        end else if (slot_end) begin
            cur   <= nxt_flags;
            pix_q <= (nxt_flags.act && pix_valid) ? pix_data : 24'd0;
        end
    end

    // Sticky record of any active dot that found no pixel waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)                        underflow_o <= 1'b0;
        else if (pix_ready && !pix_valid)  underflow_o <= 1'b1;
    end

    // Pick the byte for this phase: far register, near register, direct.
    always_comb begin
        unique case (phase)
            3'd0, 3'd1: byte_sel = pix_q[7:0];
            3'd2, 3'd3: byte_sel = pix_q[15:8];
            default:    byte_sel = pix_q[23:16];
        endcase
        bus_d   = cur.act ? byte_sel : 8'd0;
        latch_d = cur.act && (phase == 3'd1 || phase == 3'd3);
        dclk_d  = (phase == PH_LAST) || (phase == 3'd0) || (phase == 3'd1);
    end

    // Register all panel-side outputs so they leave glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_o     <= '0;
            latch_o   <= 1'b0;
            dclk_o    <= 1'b0;
            de_o      <= 1'b0;
            hsync_n_o <= 1'b1;
            vsync_n_o <= 1'b1;
        end else begin
            bus_o     <= bus_d;
            latch_o   <= latch_d;
            dclk_o    <= dclk_d;
            de_o      <= cur.act;
            hsync_n_o <= ~cur.hs;
            vsync_n_o <= ~cur.vs;
        end
    end

    AST_LATCH_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_o) |-> $stable(bus_o));                             // R3
    AST_DCLK_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk_o) |-> $stable(bus_o));                              // R3
    AST_NO_LATCH_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |-> de_o);                                              // R6
    AST_BLANK_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !de_o |-> (bus_o == 8'd0));                                     // R6
    AST_LATCH_NOT_DCLK: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(latch_o) && $rose(dclk_o)));                            // R2
    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> underflow_o);                                   // R10
    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |=> !pix_ready);                                      // R9
endmodule

// File: rtl/lcd_byte_serial_drv.sv
// Top of the byte-serialized 24-bit panel driver.
// Joins the raster timing generator and the slot sequencer. Assumes the
// panel samples on the dot-clock rising edge and that the external chain
// registers capture on the latch rising edge.
module lcd_byte_serial_drv
    import lcd_drv_pkg::*;
#(
    parameter int H_ACT   = 480,
    parameter int H_SYNC  = 2,
    parameter int H_BLANK = 45,
    parameter int V_ACT   = 272,
    parameter int V_SYNC  = 10,
    parameter int V_BLANK = 16,
    parameter int V_SHOWN = 272
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pix_valid,
    output logic        pix_ready,
    input  logic [23:0] pix_data,
    output logic [7:0]  lcd_data,
    output logic        lcd_latch,
    output logic        lcd_dclk,
    output logic        lcd_de,
    output logic        lcd_hsync_n,
    output logic        lcd_vsync_n,
    output logic        underflow
);
    logic [2:0] phase;
    logic       slot_end;
    dot_flags_t nxt_flags;

    lcd_dot_timing #(
        .H_ACT(H_ACT), .H_SYNC(H_SYNC), .H_BLANK(H_BLANK),
        .V_ACT(V_ACT), .V_SYNC(V_SYNC), .V_BLANK(V_BLANK), .V_SHOWN(V_SHOWN)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .slot_end(slot_end), .nxt_flags(nxt_flags)
    );

    lcd_slot_seq u_seq (
        .clk(clk), .rst_n(rst_n), .phase(phase), .slot_end(slot_end),
        .nxt_flags(nxt_flags), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_ready(pix_ready), .bus_o(lcd_data), .latch_o(lcd_latch),
        .dclk_o(lcd_dclk), .de_o(lcd_de), .hsync_n_o(lcd_hsync_n),
        .vsync_n_o(lcd_vsync_n), .underflow_o(underflow)
    );
endmodule

// File: tb/tb_lcd_byte_serial_drv.sv
module tb_lcd_byte_serial_drv;
    localparam int HA = 8, HS = 2, HB = 5, VA = 6, VS = 1, VB = 3, VSH = 4;
    localparam int HT = HA + HB, VT = VA + VB, VTOP = VB + (VA - VSH) / 2;
    localparam int FRAME = HT * VT;
    localparam int LIMIT = 150000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pix_valid = 1'b0;
    logic [23:0] pix_data = '0;
    logic pix_ready, lcd_latch, lcd_dclk, lcd_de, lcd_hsync_n, lcd_vsync_n, underflow;
    logic [7:0] lcd_data;

    always #4 clk = ~clk;

    lcd_byte_serial_drv #(.H_ACT(HA), .H_SYNC(HS), .H_BLANK(HB), .V_ACT(VA),
        .V_SYNC(VS), .V_BLANK(VB), .V_SHOWN(VSH)) dut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_data(pix_data), .lcd_data(lcd_data), .lcd_latch(lcd_latch),
        .lcd_dclk(lcd_dclk), .lcd_de(lcd_de), .lcd_hsync_n(lcd_hsync_n),
        .lcd_vsync_n(lcd_vsync_n), .underflow(underflow));

    int n_chk = 0, n_bad = 0, cyc = 0, dot_idx = 0, since_dot = 0, lat_cnt = 0;
    int rand_mode = 0;
    logic prev_latch = 0, prev_dclk = 0, uf_model = 0, seen_dot = 0;
    logic [7:0] prev_bus = 0, far_r = 0, near_r = 0;
    logic [23:0] expq[$];

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s dot=%0d actual=%0h expected=%0h", tag, dot_idx, act, exp);
        end
    endtask

    function automatic logic exp_de(int k);
        int h = k % HT, v = (k / HT) % VT;
        return (h >= HB) && (v >= VTOP) && (v < VTOP + VSH);
    endfunction
    function automatic logic exp_hs_n(int k);
        return !((k % HT) < HS);
    endfunction
    function automatic logic exp_vs_n(int k);
        return !(((k / HT) % VT) < VS);
    endfunction

    // Pixel source: drives shortly after each rising edge.
    initial begin
        void'($urandom(32'd20240));
        forever begin
            @(posedge clk); #1;
            pix_valid = (rand_mode == 0) ? 1'b1 : (($urandom % 4) != 0);
            case ($urandom % 8)
                0: pix_data = 24'hFFFFFF;
                1: pix_data = 24'h000000;
                default: pix_data = 24'($urandom);
            endcase
        end
    end

    // Port monitor with external register-chain model, on falling edges.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst_n) begin
                dot_idx = 0; since_dot = 0; lat_cnt = 0; seen_dot = 0;
                prev_latch = 0; prev_dclk = 0; uf_model = 0;
                far_r = 0; near_r = 0; expq.delete();
            end else begin
                since_dot++;
                if (pix_ready) begin
                    expq.push_back(pix_valid ? pix_data : 24'd0);
                    if (!pix_valid) uf_model = 1'b1;
                end
                if (lcd_latch && !prev_latch) begin
                    check(lcd_data == prev_bus, "R3 latch setup", lcd_data, prev_bus);
                    far_r = near_r; near_r = lcd_data;   // edge-triggered chain
                    lat_cnt++;
                end
                if (lcd_dclk && !prev_dclk) begin
                    logic de_e;
                    de_e = exp_de(dot_idx);
                    if (seen_dot) check(since_dot == 6, "R4 dot period", since_dot, 6);
                    check(lcd_data == prev_bus, "R3 dclk setup", lcd_data, prev_bus);
                    if (((dot_idx / HT) % VT) >= VB && ((dot_idx / HT) % VT) < VTOP)
                        check(lcd_de == 1'b0, "R8 top pad line", lcd_de, 0);
                    else
                        check(lcd_de == de_e, "R5 data enable", lcd_de, de_e);
                    check(lcd_hsync_n == exp_hs_n(dot_idx), "R7 hsync", lcd_hsync_n,
                          exp_hs_n(dot_idx));
                    check(lcd_vsync_n == exp_vs_n(dot_idx), "R7 vsync", lcd_vsync_n,
                          exp_vs_n(dot_idx));
                    check(underflow == uf_model, "R10 underflow flag", underflow, uf_model);
                    if (de_e) begin
                        logic [23:0] e;
                        e = (expq.size() > 0) ? expq.pop_front() : 24'hDEAD00;
                        check(lat_cnt == 2, "R6 strobes in active", lat_cnt, 2);
                        check({lcd_data, near_r, far_r} == e, "R2 R9 R10 pixel",
                              {lcd_data, near_r, far_r}, e);
                    end else begin
                        check(lat_cnt == 0, "R6 strobes in blank", lat_cnt, 0);
                        check(lcd_data == 0, "R6 blank bus", lcd_data, 0);
                    end
                    dot_idx++; since_dot = 0; lat_cnt = 0; seen_dot = 1;
                end
                prev_latch = lcd_latch; prev_dclk = lcd_dclk;
            end
            prev_bus = lcd_data;
        end
    end

    task automatic reset_and_check();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(lcd_data == 0 && !lcd_latch && !lcd_dclk && !lcd_de, "R1 reset outputs",
              {lcd_data, lcd_latch, lcd_dclk, lcd_de}, 0);
        check(lcd_hsync_n && lcd_vsync_n && !underflow && !pix_ready, "R1 reset flags",
              {lcd_hsync_n, lcd_vsync_n, underflow, pix_ready}, 32'hC);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(lcd_data == 0 && !lcd_de && !underflow, "R1 after release",
              {lcd_data, lcd_de, underflow}, 0);
    endtask

    task automatic run_dots(input int n);
        int start = cyc;
        while (dot_idx < n && (cyc - start) < LIMIT) @(negedge clk);
        if (dot_idx < n) check(1'b0, "watchdog", dot_idx, n);
    endtask

    initial begin
        reset_and_check();
        rand_mode = 0;
        run_dots(FRAME);
        check(underflow == 0, "R10 no underflow when fed", underflow, 0);
        rand_mode = 1;
        run_dots(3 * FRAME);
        check(underflow == 1, "R10 underflow set", underflow, 1);
        check(expq.size() == 0, "R9 one word per active dot", expq.size(), 0);
        rand_mode = 0;
        reset_and_check();
        run_dots(FRAME + HT);
        check(underflow == 0, "R10 cleared by reset", underflow, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule